// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a single programmable timer that counts down once per prescaled tick and raises a level interrupt each time the count expires. A free-running tick-enable input is divided by 1, 16 or 256. The counter then runs in one of three modes. Periodic mode reloads from a programmed limit. One-shot mode stops at zero. Free-running mode wraps over the full 16-bit or 32-bit range and ignores the limit.

Software reaches the timer through a small synchronous register port: a word index, a write strobe, write data and combinational read data. A limit can be written in two ways. The immediate form restarts the count at once. The deferred form only changes the value used at the next reload. Both the raw interrupt flag and the flag gated by the interrupt enable can be read.

Top module: `dtm_timer`

## Requirements
- R1: After reset the control word reads 0x20 (interrupt enable set, counting stopped), the count reads 0, the raw flag is clear and `irq` is low.
- R2: Word index 0 is the immediate load, 1 the current count, 2 control, 3 interrupt clear (write only), 4 raw status, 5 masked status and 6 deferred load. Index 3, index 7 and any index with upper address bits set read as 0.
- R3: A write to index 0 stores the limit, and the count takes that write's reload value on the next clock.
- R4: A write to index 6 stores the limit and leaves the count unchanged. The next expiry reloads from the new limit.
- R5: Reads of index 0 and index 6 both return the stored limit, including bits above 15 in 16-bit mode.
- R6: Control bits 3:2 set the divider: 0 and 3 divide by 1, 1 divides by 16, 2 divides by 256. The count steps only while control bit 7 (run) is set, once every divider-many cycles with `tick` high.
- R7: A step taken when the count (in the active width) is above 1 decrements it. A step taken at 1 or 0 is an expiry that sets the raw flag. In periodic mode (bit 6) an expiry reloads the limit, so a limit L gives one expiry every L steps.
- R8: In one-shot mode (bit 0, which takes priority over bit 6) an expiry leaves the count at 0 and clears the run bit. No further steps occur.
- R9: With bits 0 and 6 both clear, every reload value, including the one from an index-0 write, is 0xFFFF when bit 1 is clear and 0xFFFFFFFF when bit 1 is set.
- R10: With bit 1 clear (16-bit mode), reloads in periodic or one-shot mode use only the low 16 bits of the limit.
- R11: Any write to index 3 clears the raw flag, except that an expiry in the same cycle wins and leaves the flag set.
- R12: `irq` and the index-5 read both equal the raw flag ANDed with control bit 5. The index-4 read returns the raw flag whatever bit 5 holds.
- R13: Writes to index 1, index 4, index 5 or an unknown index change no register.
- R14: A control write restarts the divider phase and takes no step in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Tick enable fed to the divider |
| addr | input | ADDR_W | Register word index |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
The bench builds the timer with its default parameters: a 32-bit count with a 16-bit narrow mode and divider exponents 4 and 8. These values make a complete 16-bit free-running wrap (65535 steps) and full divide-by-256 intervals short enough to run out in full. A 32-bit wrap is out of reach, so the wide free-running mode is covered through its reload value and decrement only. Directed cases cover each mode, the divider restart and the clear-versus-expiry race. Seeded random register traffic and tick patterns are then compared read by read against a behavioural model in the bench.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    // Control word layout; bit positions are software visible.
    typedef struct packed {
        logic       run;       // 7
        logic       periodic;  // 6
        logic       irq_en;    // 5
        logic       spare;     // 4
        logic [1:0] div_sel;   // 3:2
        logic       wide;      // 1
        logic       single;    // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                   spare: 1'b0, div_sel: 2'd0, wide: 1'b0,
                                   single: 1'b0};

    localparam int IDX_LOAD  = 0;
    localparam int IDX_COUNT = 1;
    localparam int IDX_CTRL  = 2;
    localparam int IDX_CLR   = 3;
    localparam int IDX_RAW   = 4;
    localparam int IDX_MASK  = 5;
    localparam int IDX_DEFER = 6;

endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler #(
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] div_sel,
    output logic       step
);
    localparam int PRE_W = HI_LOG2;
    localparam logic [PRE_W-1:0] MID_TERM = PRE_W'((1 << MID_LOG2) - 1);
    localparam logic [PRE_W-1:0] HI_TERM  = PRE_W'((1 << HI_LOG2) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t       state_d, state_q;
    logic [PRE_W-1:0] term;
    logic             at_term;

    always_comb begin
        case (div_sel)
            2'd1:    term = MID_TERM;
            2'd2:    term = HI_TERM;
            default: term = '0;
        endcase
        at_term = (state_q.phase >= term);
        step    = run & tick & ~restart & at_term;

        state_d = state_q;
        if (restart) begin
            state_d.phase = '0;
        end else if (run && tick) begin
            state_d.phase = at_term ? '0 : state_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R6
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (div_sel == 2'd0 || div_sel == 2'd3 || !step));

endmodule

// File: rtl/dtm_counter.sv
module dtm_counter #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load_now,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] reload_val,
    input  logic              wide,
    input  logic              single,
    output logic [DATA_W-1:0] count,
    output logic              expire
);
    localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((64'd1 << NARROW_W) - 64'd1);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t        state_d, state_q;
    logic [DATA_W-1:0] cur;
    logic              at_end;

    always_comb begin
        cur    = wide ? state_q.cnt : (state_q.cnt & NARROW_MASK);
        at_end = (cur <= DATA_W'(1));
        expire = step & ~load_now & at_end;

        state_d = state_q;
        if (load_now) begin
            state_d.cnt = load_val;
        end else if (step) begin
            if (at_end) state_d.cnt = single ? '0 : reload_val;
            else        state_d.cnt = cur - DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count = state_q.cnt;

    // R7
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_now && wide && count > DATA_W'(1)) |=> count == $past(count) - DATA_W'(1));

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_now) |=> $stable(count));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> count == $past(load_val));

endmodule

// File: rtl/dtm_timer.sv
module dtm_timer
    import dtm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 3,
    parameter int MID_LOG2 = 4,
    parameter int HI_LOG2  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((64'd1 << NARROW_W) - 64'd1);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] limit;
        logic              raw;
    } regs_t;

    regs_t             state_d, state_q;
    logic              wr_load, wr_ctrl, wr_clr, wr_defer;
    logic              free_run;
    logic [DATA_W-1:0] load_val, reload_val, count;
    logic              step, expire;

    always_comb begin
        wr_load  = wr_en && (addr == ADDR_W'(IDX_LOAD));
        wr_ctrl  = wr_en && (addr == ADDR_W'(IDX_CTRL));
        wr_clr   = wr_en && (addr == ADDR_W'(IDX_CLR));
        wr_defer = wr_en && (addr == ADDR_W'(IDX_DEFER));
        free_run = !state_q.ctrl.single && !state_q.ctrl.periodic;

        if (free_run) begin
            load_val   = state_q.ctrl.wide ? '1 : NARROW_MASK;
            reload_val = load_val;
        end else begin
            load_val   = state_q.ctrl.wide ? wdata : (wdata & NARROW_MASK);
            reload_val = state_q.ctrl.wide ? state_q.limit : (state_q.limit & NARROW_MASK);
        end
    end

    dtm_prescaler #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ctrl),
        .run     (state_q.ctrl.run),
        .tick    (tick),
        .div_sel (state_q.ctrl.div_sel),
        .step    (step)
    );

    dtm_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_now   (wr_load),
        .load_val   (load_val),
        .reload_val (reload_val),
        .wide       (state_q.ctrl.wide),
        .single     (state_q.ctrl.single),
        .count      (count),
        .expire     (expire)
    );

    always_comb begin
        state_d = state_q;
        if (wr_load || wr_defer) state_d.limit = wdata;
        if (wr_ctrl)                              state_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        else if (expire && state_q.ctrl.single)   state_d.ctrl.run = 1'b0;
        if (expire)      state_d.raw = 1'b1;
        else if (wr_clr) state_d.raw = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ctrl  <= CTRL_RST;
            state_q.limit <= '0;
            state_q.raw   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(IDX_LOAD),
            ADDR_W'(IDX_DEFER): rdata = state_q.limit;
            ADDR_W'(IDX_COUNT): rdata = count;
            ADDR_W'(IDX_CTRL):  rdata = DATA_W'(state_q.ctrl);
            ADDR_W'(IDX_RAW):   rdata = DATA_W'(state_q.raw);
            ADDR_W'(IDX_MASK):  rdata = DATA_W'(state_q.raw & state_q.ctrl.irq_en);
            default:            rdata = '0;
        endcase
        irq = state_q.raw & state_q.ctrl.irq_en;
    end

    // R8
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && state_q.ctrl.single) |=> !state_q.ctrl.run);

    // R11
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> state_q.raw);

    // R7
    raw_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.raw) |-> $past(expire));

    // R6
    stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.ctrl.run |-> !step);

endmodule

// File: tb/dtm_timer_tb.sv
module dtm_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dtm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wr_en(wr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [7:0]  m_ctrl;
    logic [31:0] m_lim, m_cnt;
    logic        m_raw;
    int          m_pre;

    function automatic logic [31:0] m_rel(input logic [7:0] c, input logic [31:0] v);
        if (!c[0] && !c[6]) return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        return c[1] ? v : (v & 32'h0000_FFFF);
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd6: return m_lim;
            3'd1:       return m_cnt;
            3'd2:       return {24'h0, m_ctrl};
            3'd4:       return {31'h0, m_raw};
            3'd5:       return {31'h0, m_raw & m_ctrl[5]};
            default:    return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [31:0] cur;
        logic        stp, ex;
        int          dv;
        if (!rst_n) begin
            m_ctrl = 8'h20; m_lim = 0; m_cnt = 0; m_raw = 0; m_pre = 0;
        end else begin
            dv  = (m_ctrl[3:2] == 2'd1) ? 16 : (m_ctrl[3:2] == 2'd2) ? 256 : 1;
            stp = 1'b0;
            if (wr && addr == 3'd2) m_pre = 0;
            else if (m_ctrl[7] && tick) begin
                if (m_pre + 1 >= dv) begin m_pre = 0; stp = 1'b1; end
                else m_pre = m_pre + 1;
            end
            cur = m_ctrl[1] ? m_cnt : (m_cnt & 32'h0000_FFFF);
            ex  = stp && !(wr && addr == 3'd0) && (cur <= 1);
            if (wr && addr == 3'd0) m_cnt = m_rel(m_ctrl, wdata);
            else if (stp) m_cnt = (cur <= 1) ? (m_ctrl[0] ? 32'h0 : m_rel(m_ctrl, m_lim)) : cur - 1;
            if (wr && (addr == 3'd0 || addr == 3'd6)) m_lim = wdata;
            if (wr && addr == 3'd2) m_ctrl = wdata[7:0];
            else if (ex && m_ctrl[0]) m_ctrl[7] = 1'b0;
            if (ex) m_raw = 1'b1;
            else if (wr && addr == 3'd3) m_raw = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 150000, 0);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ctrl", 3'd2, 32'h20);
        rd_chk("R1 count", 3'd1, 32'h0);
        rd_chk("R1 raw", 3'd4, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R5 / R9 limit readback, free-run load value
        bus_write(3'd0, 32'd5);
        rd_chk("R5 load read", 3'd0, 32'd5);
        rd_chk("R5 defer read", 3'd6, 32'd5);
        rd_chk("R9 free-run load", 3'd1, 32'h0000_FFFF);

        // R3 / R7 periodic
        bus_write(3'd2, 32'h62);
        bus_write(3'd0, 32'd3);
        rd_chk("R3 immediate load", 3'd1, 32'd3);
        bus_write(3'd2, 32'hE2);
        run_ticks(2);
        rd_chk("R7 decrement", 3'd1, 32'd1);
        rd_chk("R7 raw before expiry", 3'd4, 32'd0);
        run_ticks(1);
        rd_chk("R7 periodic reload", 3'd1, 32'd3);
        rd_chk("R7 raw set", 3'd4, 32'd1);
        chk("R12 irq enabled", {31'h0, irq}, 32'h1);
        rd_chk("R12 masked enabled", 3'd5, 32'd1);
        bus_write(3'd3, 32'h0);
        rd_chk("R11 clear", 3'd4, 32'd0);
        chk("R11 irq after clear", {31'h0, irq}, 32'h0);

        // R12 masked
        bus_write(3'd2, 32'hC2);
        run_ticks(3);
        rd_chk("R12 raw unmasked", 3'd4, 32'd1);
        rd_chk("R12 masked zero", 3'd5, 32'd0);
        chk("R12 irq masked", {31'h0, irq}, 32'h0);
        bus_write(3'd3, 32'h0);

        // R4 deferred load
        bus_write(3'd6, 32'd5);
        rd_chk("R4 count kept", 3'd1, 32'd3);
        run_ticks(3);
        rd_chk("R4 new limit at reload", 3'd1, 32'd5);
        bus_write(3'd3, 32'h0);

        // R6 dividers
        bus_write(3'd2, 32'hC6);
        bus_write(3'd0, 32'd2);
        run_ticks(15);
        rd_chk("R6 div16 no step", 3'd1, 32'd2);
        run_ticks(1);
        rd_chk("R6 div16 step", 3'd1, 32'd1);
        bus_write(3'd2, 32'hCA);
        run_ticks(255);
        rd_chk("R6 div256 no step", 3'd1, 32'd1);
        run_ticks(1);
        rd_chk("R6 div256 step", 3'd1, 32'd2);
        bus_write(3'd3, 32'h0);
        bus_write(3'd2, 32'hCE);
        run_ticks(1);
        rd_chk("R6 code3 div1", 3'd1, 32'd1);

        // R8 one-shot with periodic bit also set
        bus_write(3'd2, 32'h63);
        bus_write(3'd0, 32'd2);
        bus_write(3'd2, 32'hE3);
        run_ticks(2);
        rd_chk("R8 count zero", 3'd1, 32'd0);
        rd_chk("R8 run cleared", 3'd2, 32'h63);
        rd_chk("R8 raw", 3'd4, 32'd1);
        run_ticks(3);
        rd_chk("R8 stays stopped", 3'd1, 32'd0);
        bus_write(3'd3, 32'h0);

        // R9 / R10 widths
        bus_write(3'd2, 32'h20);
        bus_write(3'd0, 32'h0001_2345);
        rd_chk("R9 narrow free-run load", 3'd1, 32'h0000_FFFF);
        rd_chk("R5 wide limit kept", 3'd0, 32'h0001_2345);
        bus_write(3'd2, 32'hA0);
        run_ticks(32'hFFFE);
        rd_chk("R9 before wrap", 3'd1, 32'd1);
        rd_chk("R9 no raw yet", 3'd4, 32'd0);
        run_ticks(1);
        rd_chk("R9 wrap reload", 3'd1, 32'h0000_FFFF);
        rd_chk("R9 wrap raw", 3'd4, 32'd1);
        bus_write(3'd3, 32'h0);
        bus_write(3'd2, 32'h60);
        bus_write(3'd0, 32'h0001_0003);
        rd_chk("R10 narrow limit", 3'd1, 32'd3);
        bus_write(3'd2, 32'h22);
        bus_write(3'd0, 32'd7);
        rd_chk("R9 wide free-run load", 3'd1, 32'hFFFF_FFFF);

        // R13 ignored writes, R2 unknown reads
        bus_write(3'd1, 32'h55);
        rd_chk("R13 value write ignored", 3'd1, 32'hFFFF_FFFF);
        bus_write(3'd4, 32'h1);
        rd_chk("R13 raw write ignored", 3'd4, 32'd0);
        bus_write(3'd7, 32'hAB);
        rd_chk("R13 limit intact", 3'd0, 32'd7);
        rd_chk("R13 ctrl intact", 3'd2, 32'h22);
        rd_chk("R2 index7 reads zero", 3'd7, 32'd0);
        rd_chk("R2 clear reads zero", 3'd3, 32'd0);

        // R14 divider restart on control write
        bus_write(3'd2, 32'h66);
        bus_write(3'd0, 32'd4);
        bus_write(3'd2, 32'hE6);
        run_ticks(10);
        bus_write(3'd2, 32'hE6);
        run_ticks(15);
        rd_chk("R14 restarted phase", 3'd1, 32'd4);
        run_ticks(1);
        rd_chk("R14 step after full count", 3'd1, 32'd3);

        // R11 expiry beats clear
        bus_write(3'd2, 32'hE2);
        bus_write(3'd0, 32'd1);
        @(negedge clk);
        addr = 3'd3; wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        rd_chk("R11 expiry wins over clear", 3'd4, 32'd1);
        bus_write(3'd3, 32'h0);
        rd_chk("R11 later clear", 3'd4, 32'd0);

        // R2 / R7 random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [2:0] a;
            @(negedge clk);
            wr = 1'b0;
            a = 3'($urandom_range(0, 7));
            rd_chk("R2 random read", a, m_read(a));
            chk("R12 random irq", {31'h0, irq}, {31'h0, m_raw & m_ctrl[5]});
            r = $urandom_range(0, 9);
            if (r < 3) begin
                addr = 3'($urandom_range(0, 7));
                wr = 1'b1;
                if (addr == 3'd2) begin
                    wdata = {24'h0, 8'($urandom) & 8'hF3};
                    if ($urandom_range(0, 3) == 0) wdata[3:2] = 2'($urandom_range(0, 3));
                end else begin
                    wdata = 32'($urandom_range(0, 12));
                end
            end
            tick = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        rd_chk("R7 final count", 3'd1, m_cnt);

        done = 1'b1;
        finish_run();
    end
endmodule